// File: doc/BRIEF.md
# Decimal Branch Resolver with Alternate-Path Record

This block decides where a decimal machine goes next after a transfer-of-control instruction. It receives the opcode, up to four operand words from the fast registers, one addressable flip-flop bit, a five-digit target address and the current program counter. It evaluates the test and returns the new program counter. The result appears after a cycle count that depends on the instruction and on whether the branch is taken. The block also reports that count.

Beside the decision, the block keeps an alternate-path register. For every instruction that could redirect control, this register holds the address that would have been reached had the decision gone the other way. Two read operations return that register as a full machine word: one form is meant for memory and the other for a fast register. A subroutine call also produces the return-jump word that the caller writes into memory.

Words are 12 BCD digits. Digit 11 is the sign digit: 0 means plus and any other value means minus. Digits 10..0 hold the magnitude. Addresses are 5 BCD digits. Memory, the register file and the arithmetic are outside this block.

Top module: `branch_path_unit`

## Requirements
- R1: After reset, `busy`, `done`, `taken`, `word_valid`, `word_to_mem` and `pc_next` are all 0, and the alternate-path register holds 00000.
- R2: The single-word tests compare numeric values, so minus zero equals plus zero. The opcodes are: 0 = A equals B, 1 = A greater than B (signed), 2 = A is zero, 3 = A greater than zero, 4 = A negative (minus sign with a nonzero magnitude). When the test holds, `pc_next` is `addr_m` and `taken` is 1. Otherwise `pc_next` is `pc_in`+1 and `taken` is 0.
- R3: Opcode 5 takes the branch when `ff_bit` is 1 and does not take it when `ff_bit` is 0.
- R4: The double-word tests treat A,B as one number and C,D as another. Each number takes its sign from A or C, and its 22-digit magnitude is the magnitude of A or C followed by that of B or D. The sign digits of B and D are ignored. Opcode 6 tests equality and opcode 7 tests signed greater-than. The outcome drives `pc_next` and `taken` as in R2.
- R5: `done` is a one-cycle pulse that comes on the L-th rising edge after the edge that accepted `start`, and `lat_cycles` equals L. For opcodes 0-5, L is 12 when the branch is taken and 4 when it is not. For opcodes 6-7, L is 16 when taken and 8 when not.
- R6: Opcode 8 (jump) always sets `pc_next` to `addr_m` and `taken` to 1, with L = 8.
- R7: Opcode 9 (call) sets `pc_next` to `addr_m`+1 and `taken` to 1, with L = 12. It raises `word_valid` and `word_to_mem`, and `word_out` carries digits 0,9,0,0,0,0,0 followed by `pc_in`+1.
- R8: Opcodes 0-9 update the alternate-path register. It becomes `pc_in`+1 when the branch is taken and `addr_m` when it is not.
- R9: Opcode 10 returns digits 9,9,0,0,0,0,0 followed by the register, with `word_to_mem` set to 1. Opcode 11 returns digits 0,0,0,0,0,0,0 followed by the register, with `word_to_mem` set to 0. Both raise `word_valid`, set `pc_next` to `pc_in`+1 and `taken` to 0, take L = 4, and leave the register unchanged.
- R10: Address increments are decimal and wrap from 99999 to 00000. This applies to both `pc_in`+1 and `addr_m`+1.
- R11: A `start` that arrives while `busy` is 1 is ignored. The outputs of the operation in flight, and the time at which it finishes, do not change.
- R12: Opcodes 12-15 set `pc_next` to `pc_in`+1 and `taken` to 0, take L = 4 and leave the alternate-path register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation (taken only when not busy) |
| op | input | 4 | Operation code |
| word_a | input | 48 | Fast register A |
| word_b | input | 48 | Fast register A+1 |
| word_c | input | 48 | Fast register A+2 |
| word_d | input | 48 | Fast register A+3 |
| ff_bit | input | 1 | Addressed flip-flop state |
| addr_m | input | 20 | Target address, 5 BCD digits |
| pc_in | input | 20 | Current program counter, 5 BCD digits |
| busy | output | 1 | Operation in flight |
| done | output | 1 | One-cycle completion pulse |
| taken | output | 1 | Control was transferred |
| pc_next | output | 20 | New program counter |
| word_valid | output | 1 | `word_out` carries a word |
| word_to_mem | output | 1 | Destination of `word_out` is memory |
| word_out | output | 48 | Return-jump or alternate-path word |
| lat_cycles | output | 6 | Latency of the operation |

## Verification
The bench builds the block with its default parameters: 12-digit words, 5-digit addresses and the latencies 4, 8, 12 and 16. With these values, the taken and not-taken cycle counts of every class can be measured directly. The default address width also puts the 99999 wrap within reach of both incrementers. Every recording operation is followed by a read-back of the alternate-path register in both word forms.

// File: rtl/branch_path_pkg.sv
// Shared opcode type for the branch resolver.
// Assumes a 4-bit opcode; codes 12-15 are unlisted and act as no-branch.
package branch_path_pkg;
    typedef enum logic [3:0] {
        OP_TEQ  = 4'd0,
        OP_TGT  = 4'd1,
        OP_TZR  = 4'd2,
        OP_TPOS = 4'd3,
        OP_TNEG = 4'd4,
        OP_TFF  = 4'd5,
        OP_DEQ  = 4'd6,
        OP_DGT  = 4'd7,
        OP_JMP  = 4'd8,
        OP_CALL = 4'd9,
        OP_RDM  = 4'd10,
        OP_RDR  = 4'd11
    } op_e;
endpackage

// File: rtl/bcd_incr.sv
// Adds one to a packed BCD number, wrapping from all nines to zero.
// Assumes every input digit is a valid BCD digit.
module bcd_incr #(
    parameter int DIGITS = 5
) (
    input  logic [4*DIGITS-1:0] val_in,
    output logic [4*DIGITS-1:0] val_out
);
    logic [DIGITS:0] carry;
    assign carry[0] = 1'b1;

    for (genvar i = 0; i < DIGITS; i++) begin : g_digit
        // Ripple one decimal digit with its incoming carry.
        always_comb begin
            if (carry[i] && val_in[4*i +: 4] == 4'd9) begin
                val_out[4*i +: 4] = 4'd0;
                carry[i+1]        = 1'b1;
            end else begin
                val_out[4*i +: 4] = val_in[4*i +: 4] + {3'b000, carry[i]};
                carry[i+1]        = 1'b0;
            end
        end
    end

    logic unused_carry_out;
    assign unused_carry_out = carry[DIGITS];
endmodule

// File: rtl/sm_compare.sv
// Signed-magnitude decimal compare: equal and greater-than on numeric value.
// Assumes a nonzero sign digit means minus and that minus zero equals plus zero.
module sm_compare #(
    parameter int DIGITS = 11
) (
    input  logic [3:0]          sign_x,
    input  logic [4*DIGITS-1:0] mag_x,
    input  logic [3:0]          sign_y,
    input  logic [4*DIGITS-1:0] mag_y,
    output logic                is_eq,
    output logic                is_gt
);
    logic zero_x, zero_y, neg_x, neg_y;

    // Classify each operand by sign and zero.
    always_comb begin
        zero_x = (mag_x == '0);
        zero_y = (mag_y == '0);
        neg_x  = (sign_x != 4'd0) && !zero_x;
        neg_y  = (sign_y != 4'd0) && !zero_y;
    end

    // BCD digit order keeps numeric order, so magnitudes compare as binary.
    always_comb begin
        if (neg_x != neg_y) begin
            is_eq = 1'b0;
            is_gt = !neg_x;
        end else if (!neg_x) begin
            is_eq = (mag_x == mag_y);
            is_gt = (mag_x > mag_y);
        end else begin
            is_eq = (mag_x == mag_y);
            is_gt = (mag_x < mag_y);
        end
    end
endmodule

// File: rtl/branch_cond.sv
// Evaluates the test of a conditional-transfer opcode on the operand words.
// Assumes word = sign digit on top, magnitude digits below; pairs join magnitudes.
module branch_cond
    import branch_path_pkg::*;
#(
    parameter int WORD_DIGITS = 12
) (
    input  op_e                    opc,
    input  logic [4*WORD_DIGITS-1:0] wa,
    input  logic [4*WORD_DIGITS-1:0] wb,
    input  logic [4*WORD_DIGITS-1:0] wc,
    input  logic [4*WORD_DIGITS-1:0] wd,
    input  logic                   ff,
    output logic                   cond_true
);
    localparam int MAG   = WORD_DIGITS - 1;
    localparam int MAGB  = 4 * MAG;
    localparam int SGN   = 4 * WORD_DIGITS - 4;

    logic eq1, gt1, eq2, gt2, a_zero, a_plus;

    sm_compare #(.DIGITS(MAG)) u_cmp_single (
        .sign_x(wa[SGN +: 4]), .mag_x(wa[MAGB-1:0]),
        .sign_y(wb[SGN +: 4]), .mag_y(wb[MAGB-1:0]),
        .is_eq(eq1), .is_gt(gt1)
    );

    sm_compare #(.DIGITS(2*MAG)) u_cmp_double (
        .sign_x(wa[SGN +: 4]), .mag_x({wa[MAGB-1:0], wb[MAGB-1:0]}),
        .sign_y(wc[SGN +: 4]), .mag_y({wc[MAGB-1:0], wd[MAGB-1:0]}),
        .is_eq(eq2), .is_gt(gt2)
    );

    logic unused_signs;
    assign unused_signs = ^{wd[SGN +: 4]};

    // Tests of A against zero.
    always_comb begin
        a_zero = (wa[MAGB-1:0] == '0);
        a_plus = (wa[SGN +: 4] == 4'd0);
    end

    // Select the outcome for the opcode.
    always_comb begin
        unique case (opc)
            OP_TEQ:  cond_true = eq1;
            OP_TGT:  cond_true = gt1;
            OP_TZR:  cond_true = a_zero;
            OP_TPOS: cond_true = a_plus && !a_zero;
            OP_TNEG: cond_true = !a_plus && !a_zero;
            OP_TFF:  cond_true = ff;
            OP_DEQ:  cond_true = eq2;
            OP_DGT:  cond_true = gt2;
            default: cond_true = 1'b0;
        endcase
    end
endmodule

// File: rtl/alt_path_reg.sv
// Holds the address of the path not followed by the last transfer decision.
// Assumes rec_en pulses once per accepted transfer-capable instruction.
module alt_path_reg #(
    parameter int ADDR_DIGITS = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     rec_en,
    input  logic                     was_taken,
    input  logic [4*ADDR_DIGITS-1:0] target,
    input  logic [4*ADDR_DIGITS-1:0] seq_next,
    output logic [4*ADDR_DIGITS-1:0] alt_addr
);
    // Record the opposite outcome of each decision.
    always_ff @(posedge clk) begin
        if (!rst_n)
            alt_addr <= '0;
        else if (rec_en)
            alt_addr <= was_taken ? seq_next : target;
    end

    assert_alt_taken_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rec_en && was_taken |=> alt_addr == $past(seq_next));
    assert_alt_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rec_en && !was_taken |=> alt_addr == $past(target));
    assert_alt_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rec_en |=> $stable(alt_addr));
endmodule

// File: rtl/branch_path_unit.sv
// Resolves transfer-of-control instructions: next PC, latency, return-jump
// word and read-out of the alternate-path record.
// Assumes BCD inputs and all latency parameters of at least one cycle.
module branch_path_unit
    import branch_path_pkg::*;
#(
    parameter int WORD_DIGITS = 12,
    parameter int ADDR_DIGITS = 5,
    parameter int LAT_W       = 6,
    parameter int LAT_S_T     = 12,
    parameter int LAT_S_N     = 4,
    parameter int LAT_D_T     = 16,
    parameter int LAT_D_N     = 8,
    parameter int LAT_JMP     = 8,
    parameter int LAT_CALL    = 12,
    parameter int LAT_MISC    = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [3:0]               op,
    input  logic [4*WORD_DIGITS-1:0] word_a,
    input  logic [4*WORD_DIGITS-1:0] word_b,
    input  logic [4*WORD_DIGITS-1:0] word_c,
    input  logic [4*WORD_DIGITS-1:0] word_d,
    input  logic                     ff_bit,
    input  logic [4*ADDR_DIGITS-1:0] addr_m,
    input  logic [4*ADDR_DIGITS-1:0] pc_in,
    output logic                     busy,
    output logic                     done,
    output logic                     taken,
    output logic [4*ADDR_DIGITS-1:0] pc_next,
    output logic                     word_valid,
    output logic                     word_to_mem,
    output logic [4*WORD_DIGITS-1:0] word_out,
    output logic [LAT_W-1:0]         lat_cycles
);
    localparam int AW  = 4 * ADDR_DIGITS;
    localparam int WW  = 4 * WORD_DIGITS;
    localparam int PAD = 4 * (WORD_DIGITS - 3 - ADDR_DIGITS);

    op_e              opc;
    logic             accept, cond_true, rec, take;
    logic             is_dbl, is_test, w_val, w_mem;
    logic [AW-1:0]    pc_plus1, m_plus1, alt_addr, nxt;
    logic [WW-1:0]    word;
    logic [LAT_W-1:0] lat, cnt;

    assign opc    = op_e'(op);
    assign accept = start && !busy;

    bcd_incr #(.DIGITS(ADDR_DIGITS)) u_inc_pc (.val_in(pc_in),  .val_out(pc_plus1));
    bcd_incr #(.DIGITS(ADDR_DIGITS)) u_inc_m  (.val_in(addr_m), .val_out(m_plus1));

    branch_cond #(.WORD_DIGITS(WORD_DIGITS)) u_cond (
        .opc(opc), .wa(word_a), .wb(word_b), .wc(word_c), .wd(word_d),
        .ff(ff_bit), .cond_true(cond_true)
    );

    alt_path_reg #(.ADDR_DIGITS(ADDR_DIGITS)) u_alt (
        .clk(clk), .rst_n(rst_n), .rec_en(accept && rec), .was_taken(take),
        .target(addr_m), .seq_next(pc_plus1), .alt_addr(alt_addr)
    );

    // Classify the opcode.
    always_comb begin
        is_test = (op <= 4'd7);
        is_dbl  = (opc == OP_DEQ) || (opc == OP_DGT);
        rec     = (op <= 4'd9);
        take    = (is_test && cond_true) || (opc == OP_JMP) || (opc == OP_CALL);
    end

    // Form next PC, latency and output word.
    always_comb begin
        nxt   = take ? addr_m : pc_plus1;
        w_val = 1'b0;
        w_mem = 1'b0;
        word  = '0;
        if (is_test)
            lat = is_dbl ? (take ? LAT_W'(LAT_D_T) : LAT_W'(LAT_D_N))
                         : (take ? LAT_W'(LAT_S_T) : LAT_W'(LAT_S_N));
        else
            lat = LAT_W'(LAT_MISC);
        unique case (opc)
            OP_JMP:  lat = LAT_W'(LAT_JMP);
            OP_CALL: begin
                lat   = LAT_W'(LAT_CALL);
                nxt   = m_plus1;
                w_val = 1'b1;
                w_mem = 1'b1;
                word  = {4'h0, 4'h9, 4'h0, {PAD{1'b0}}, pc_plus1};
            end
            OP_RDM: begin
                w_val = 1'b1;
                w_mem = 1'b1;
                word  = {4'h9, 4'h9, 4'h0, {PAD{1'b0}}, alt_addr};
            end
            OP_RDR: begin
                w_val = 1'b1;
                word  = {12'h000, {PAD{1'b0}}, alt_addr};
            end
            default: ;
        endcase
    end

    // Capture results on accept and count down the latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy        <= 1'b0;
            done        <= 1'b0;
            taken       <= 1'b0;
            pc_next     <= '0;
            word_valid  <= 1'b0;
            word_to_mem <= 1'b0;
            word_out    <= '0;
            lat_cycles  <= '0;
            cnt         <= '0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                busy        <= 1'b1;
                taken       <= take;
                pc_next     <= nxt;
                word_valid  <= w_val;
                word_to_mem <= w_mem;
                word_out    <= word;
                lat_cycles  <= lat;
                cnt         <= lat - 1'b1;
            end else if (busy) begin
                if (cnt == '0) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    cnt <= cnt - 1'b1;
                end
            end
        end
    end

    assert_busy_done_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));
    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_taken_target_R2: assert property (@(posedge clk) disable iff (!rst_n)
        accept && is_test && cond_true |=> pc_next == $past(addr_m) && taken);
    assert_ignore_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
        busy && start |=> $stable(pc_next) && $stable(taken) && $stable(lat_cycles));
endmodule

// File: tb/tb_branch_path_unit.sv
module tb_branch_path_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  op = '0;
    logic [47:0] wa = '0, wb = '0, wc = '0, wd = '0;
    logic        ff = 1'b0;
    logic [19:0] m = '0, pc = '0;
    logic        busy, done, taken, word_valid, word_to_mem;
    logic [19:0] pc_next;
    logic [47:0] word_out;
    logic [5:0]  lat_cycles;

    int checks = 0;
    int errors = 0;
    logic [19:0] c2_exp = '0;

    always #4 clk = ~clk;

    branch_path_unit dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op),
        .word_a(wa), .word_b(wb), .word_c(wc), .word_d(wd),
        .ff_bit(ff), .addr_m(m), .pc_in(pc),
        .busy(busy), .done(done), .taken(taken), .pc_next(pc_next),
        .word_valid(word_valid), .word_to_mem(word_to_mem),
        .word_out(word_out), .lat_cycles(lat_cycles)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [47:0] act, input logic [47:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [19:0] inc5(input logic [19:0] v);
        int n;
        logic [19:0] r;
        n = 0;
        for (int i = 4; i >= 0; i--) n = n * 10 + int'(v[4*i +: 4]);
        n = (n + 1) % 100000;
        for (int i = 0; i < 5; i++) begin
            r[4*i +: 4] = 4'(n % 10);
            n = n / 10;
        end
        return r;
    endfunction

    // Issue one operation, measure latency, check pc, taken, latency.
    task automatic run(input logic [3:0] o, input logic [47:0] a, input logic [47:0] b,
                       input logic [47:0] c, input logic [47:0] d, input logic f,
                       input logic [19:0] mm, input logic [19:0] p,
                       input logic [19:0] exp_pc, input logic exp_tk,
                       input int exp_lat, input string req);
        int n;
        @(negedge clk);
        while (busy) @(negedge clk);
        op = o; wa = a; wb = b; wc = c; wd = d; ff = f; m = mm; pc = p;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 1;
        while (!done && n < 100) begin
            @(negedge clk);
            n++;
        end
        chk(n - 1 == exp_lat, req, "latency", 48'(n - 1), 48'(exp_lat));
        chk(lat_cycles == 6'(exp_lat), req, "lat_cycles", 48'(lat_cycles), 48'(exp_lat));
        chk(pc_next == exp_pc, req, "pc_next", 48'(pc_next), 48'(exp_pc));
        chk(taken == exp_tk, req, "taken", 48'(taken), 48'(exp_tk));
        if (o <= 4'd9) c2_exp = exp_tk ? inc5(p) : mm;
    endtask

    // Read the alternate-path register in both forms (R9, R8).
    task automatic check_alt(input string req);
        run(4'd11, '0, '0, '0, '0, 1'b0, 20'h11111, 20'h00200, 20'h00201, 1'b0, 4, "R9");
        chk(word_out == {28'h0, c2_exp}, req, "register-form word", word_out, {28'h0, c2_exp});
        chk(word_valid && !word_to_mem, "R9", "register-form flags",
            {46'h0, word_valid, word_to_mem}, 48'h2);
        run(4'd10, '0, '0, '0, '0, 1'b0, 20'h22222, 20'h00300, 20'h00301, 1'b0, 4, "R9");
        chk(word_out == {28'h9900000, c2_exp}, req, "memory-form word", word_out,
            {28'h9900000, c2_exp});
        chk(word_valid && word_to_mem, "R9", "memory-form flags",
            {46'h0, word_valid, word_to_mem}, 48'h3);
    endtask

    task automatic t_reset();
        chk(!busy && !done && !taken && !word_valid && !word_to_mem, "R1", "control outputs",
            {43'h0, busy, done, taken, word_valid, word_to_mem}, 48'h0);
        chk(pc_next == 20'h0, "R1", "pc_next", 48'(pc_next), 48'h0);
        check_alt("R1");
    endtask

    task automatic t_single();
        run(4'd0, 48'h0_00000000123, 48'h0_00000000123, '0, '0, 0, 20'h01000, 20'h00050, 20'h01000, 1, 12, "R2");
        run(4'd0, 48'h0_00000000123, 48'h1_00000000123, '0, '0, 0, 20'h01000, 20'h00050, 20'h00051, 0, 4, "R2");
        run(4'd0, 48'h0_00000000000, 48'h1_00000000000, '0, '0, 0, 20'h01010, 20'h00060, 20'h01010, 1, 12, "R2");
        run(4'd1, 48'h1_00000000005, 48'h1_00000000007, '0, '0, 0, 20'h02000, 20'h00070, 20'h02000, 1, 12, "R2");
        run(4'd1, 48'h0_00000000005, 48'h0_00000000007, '0, '0, 0, 20'h02000, 20'h00070, 20'h00071, 0, 4, "R2");
        check_alt("R8");
        run(4'd1, 48'h1_00000000001, 48'h0_00000000000, '0, '0, 0, 20'h02000, 20'h00079, 20'h00080, 0, 4, "R2");
        run(4'd2, 48'h1_00000000000, '0, '0, '0, 0, 20'h03000, 20'h00080, 20'h03000, 1, 12, "R2");
        run(4'd2, 48'h0_00000000001, '0, '0, '0, 0, 20'h03000, 20'h00080, 20'h00081, 0, 4, "R2");
        run(4'd3, 48'h0_00000000003, '0, '0, '0, 0, 20'h04000, 20'h00090, 20'h04000, 1, 12, "R2");
        run(4'd3, 48'h0_00000000000, '0, '0, '0, 0, 20'h04000, 20'h00090, 20'h00091, 0, 4, "R2");
        run(4'd3, 48'h1_00000000003, '0, '0, '0, 0, 20'h04000, 20'h00090, 20'h00091, 0, 4, "R2");
        run(4'd4, 48'h1_00000000003, '0, '0, '0, 0, 20'h05000, 20'h00099, 20'h05000, 1, 12, "R2");
        run(4'd4, 48'h1_00000000000, '0, '0, '0, 0, 20'h05000, 20'h00099, 20'h00100, 0, 4, "R2");
        check_alt("R8");
    endtask

    task automatic t_flag();
        run(4'd5, '0, '0, '0, '0, 1, 20'h06000, 20'h00400, 20'h06000, 1, 12, "R3");
        run(4'd5, '0, '0, '0, '0, 0, 20'h06000, 20'h00400, 20'h00401, 0, 4, "R3");
        check_alt("R8");
    endtask

    task automatic t_double();
        run(4'd6, 48'h0_00000000001, 48'h1_00000000042, 48'h0_00000000001, 48'h0_00000000042,
            0, 20'h07000, 20'h00500, 20'h07000, 1, 16, "R4");
        run(4'd6, 48'h0_00000000001, 48'h0_00000000042, 48'h0_00000000001, 48'h0_00000000043,
            0, 20'h07000, 20'h00500, 20'h00501, 0, 8, "R4");
        run(4'd7, 48'h0_00000000001, 48'h0_00000000002, 48'h0_00000000001, 48'h0_00000000001,
            0, 20'h07100, 20'h00510, 20'h07100, 1, 16, "R4");
        run(4'd7, 48'h1_00000000000, 48'h0_00000000005, 48'h1_00000000000, 48'h0_00000000003,
            0, 20'h07100, 20'h00510, 20'h00511, 0, 8, "R4");
        run(4'd7, 48'h0_00000000000, 48'h0_99999999999, 48'h0_00000000001, 48'h0_00000000000,
            0, 20'h07200, 20'h00520, 20'h00521, 0, 8, "R4");
        check_alt("R8");
    endtask

    task automatic t_jump_call();
        run(4'd8, '0, '0, '0, '0, 0, 20'h12345, 20'h00600, 20'h12345, 1, 8, "R6");
        check_alt("R8");
        run(4'd9, '0, '0, '0, '0, 0, 20'h08000, 20'h00700, 20'h08001, 1, 12, "R7");
        chk(word_out == {28'h0900000, 20'h00701}, "R7", "link word", word_out, {28'h0900000, 20'h00701});
        chk(word_valid && word_to_mem, "R7", "link flags", {46'h0, word_valid, word_to_mem}, 48'h3);
        check_alt("R8");
        run(4'd9, '0, '0, '0, '0, 0, 20'h99999, 20'h99999, 20'h00000, 1, 12, "R10");
        chk(word_out == {28'h0900000, 20'h00000}, "R10", "link word wrap", word_out, {28'h0900000, 20'h0});
        run(4'd0, 48'h0_1, 48'h0_2, '0, '0, 0, 20'h04444, 20'h99999, 20'h00000, 0, 4, "R10");
        check_alt("R10");
    endtask

    task automatic t_unlisted();
        for (int k = 12; k < 16; k++) begin
            run(4'(k), 48'h0_1, 48'h0_1, '0, '0, 1, 20'h05555, 20'h00800, 20'h00801, 0, 4, "R12");
        end
        check_alt("R12");
    endtask

    task automatic t_busy();
        int n;
        @(negedge clk);
        while (busy) @(negedge clk);
        op = 4'd7; wa = 48'h0_5; wb = '0; wc = 48'h0_1; wd = '0; m = 20'h09000; pc = 20'h00900;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        op = 4'd8; m = 20'h09999; pc = 20'h00001; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 3;
        while (!done && n < 100) begin
            @(negedge clk);
            n++;
        end
        chk(n - 1 == 16, "R11", "latency under extra start", 48'(n - 1), 48'd16);
        chk(pc_next == 20'h09000, "R11", "pc_next kept", 48'(pc_next), 48'h09000);
        c2_exp = 20'h00901;
        repeat (3) @(negedge clk);
        chk(!busy && !done, "R11", "no second operation", {46'h0, busy, done}, 48'h0);
        check_alt("R11");
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_single();
        t_flag();
        t_double();
        t_jump_call();
        t_unlisted();
        t_busy();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule